// File: doc/BRIEF.md
# Two-Wide Static Issue Packet Checker

This block is the issue stage of a statically scheduled, two-wide, in-order pipeline. Each cycle fetch presents one aligned 64-bit packet that holds two 32-bit instructions. The lower slot may hold only arithmetic or branch work. The upper slot may hold only a memory access. Either slot may hold a no-op. The block checks these slot rules and looks for two hazards. The first is a memory access that needs, as an operand, a register that the arithmetic slot of the same packet writes. The second is an instruction that reads a register filled by a load issued in the cycle before.

Depending on what it finds, the block issues both slots together, splits the packet over two cycles, stalls for one cycle, or rejects the packet. It drives one issue-valid line per slot, a hold line that tells fetch to keep presenting the same packet, and an illegal-packet flag.

Top module: `dual_issue_checker`

## Requirements
- R1: After reset no load is pending and no split is in progress. With no packet presented, all outputs are low, and the first packet then issues as if nothing came before it.
- R2: Slot 0 is packet bits [31:0] and slot 1 is bits [63:32]. The class comes from bits [31:26]. An all-zero word is a no-op. Any other word with opcode 0x00 is register-register arithmetic: it writes [15:11] and reads [25:21] and [20:16]. Opcode 0x08 is immediate arithmetic: it writes [20:16] and reads [25:21]. Opcode 0x04 is a branch: it reads [25:21] and [20:16] and writes nothing. Opcode 0x23 is a load: it writes [20:16] and reads [25:21]. Opcode 0x2B is a store: it reads [25:21] and [20:16]. Every other opcode is illegal.
- R3: If slot 0 is not a no-op, arithmetic or branch, or if slot 1 is not a no-op, load or store, the illegal flag rises and neither slot issues. Hold stays low. This check takes priority over both hazard checks.
- R4: A legal packet with no hazard issues both slots in the same cycle, with hold low.
- R5: A load that issued in the previous cycle and has a nonzero destination causes a one-cycle stall if either slot reads that register. During the stall nothing issues and hold is high. In the next cycle the packet is evaluated again without that load.
- R6: If slot 1 reads a nonzero register written by slot 0, the packet splits. In the first cycle only slot 0 issues and hold is high. In the second cycle only slot 1 issues and hold is low. The load-use stall of R5 takes priority over the split.
- R7: Register zero never creates a dependency, whether within a packet or across packets.
- R8: An issue-valid line rises only for a slot that is not a no-op. A packet of two no-ops issues nothing and does not hold.
- R9: In a cycle without a valid packet, every output is low and any pending load is dropped, because the empty cycle already covers the load latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_word | input | 64 | Packet; slot 0 in the low half |
| issue0_o | output | 1 | Slot 0 instruction issues this cycle |
| issue1_o | output | 1 | Slot 1 instruction issues this cycle |
| fetch_hold_o | output | 1 | Fetch must present the same packet next cycle |
| illegal_o | output | 1 | Packet breaks the slot-type rule and is dropped |

## Verification
The assertions assume that fetch obeys the hold line. Whenever hold is high, the next cycle brings the same packet with the valid line still asserted, so the second half of a split always sees its own packet. The random stimulus respects this by reusing the held packet until hold falls, and it inserts empty cycles only when no hold is pending. Register numbers are drawn from a small pool that includes zero, so hazards and the zero-register exemption come up often.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int INSN_W = 32;
  localparam int REG_W  = 5;
  localparam int OPC_W  = 6;
  localparam int PKT_W  = 2 * INSN_W;
  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int RS_LSB  = OPC_LSB - REG_W;
  localparam int RT_LSB  = RS_LSB - REG_W;
  localparam int RD_LSB  = RT_LSB - REG_W;

  localparam logic [OPC_W-1:0] OP_ALUR  = 6'h00;
  localparam logic [OPC_W-1:0] OP_ALUI  = 6'h08;
  localparam logic [OPC_W-1:0] OP_BR    = 6'h04;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

  typedef enum logic [2:0] {
    K_NOP, K_ALUR, K_ALUI, K_BR, K_LOAD, K_STORE, K_BAD
  } kind_e;

  typedef struct packed {
    logic             a_en;
    logic [REG_W-1:0] a;
    logic             b_en;
    logic [REG_W-1:0] b;
  } srcs_t;

  typedef struct packed {
    kind_e            kind;
    logic             wr_en;
    logic [REG_W-1:0] wr_reg;
    srcs_t            src;
  } dec_t;

  function automatic dec_t crack(input logic [INSN_W-1:0] w);
    dec_t             d;
    logic [REG_W-1:0] rs, rt, rd;
    rs = w[RS_LSB +: REG_W];
    rt = w[RT_LSB +: REG_W];
    rd = w[RD_LSB +: REG_W];
    d = '0;
    d.kind = K_BAD;
    if (w == '0) begin
      d.kind = K_NOP;
    end else begin
      case (w[OPC_LSB +: OPC_W])
        OP_ALUR:  begin d.kind = K_ALUR;  d.wr_en = 1'b1; d.wr_reg = rd;
                        d.src = '{1'b1, rs, 1'b1, rt}; end
        OP_ALUI:  begin d.kind = K_ALUI;  d.wr_en = 1'b1; d.wr_reg = rt;
                        d.src = '{1'b1, rs, 1'b0, '0}; end
        OP_BR:    begin d.kind = K_BR;
                        d.src = '{1'b1, rs, 1'b1, rt}; end
        OP_LOAD:  begin d.kind = K_LOAD;  d.wr_en = 1'b1; d.wr_reg = rt;
                        d.src = '{1'b1, rs, 1'b0, '0}; end
        OP_STORE: begin d.kind = K_STORE;
                        d.src = '{1'b1, rs, 1'b1, rt}; end
        default:  d.kind = K_BAD;
      endcase
    end
    return d;
  endfunction

  // True when the operand set reads register r; register zero never counts.
  function automatic logic uses_reg(input srcs_t s, input logic [REG_W-1:0] r);
    return (r != '0) && ((s.a_en && s.a == r) || (s.b_en && s.b == r));
  endfunction
endpackage

// File: rtl/dis_slot_decode.sv
module dis_slot_decode
  import dis_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec,
  output logic              legal
);
  assign dec = crack(insn);

  generate
    if (SLOT == 0) begin : g_arith_slot
      assign legal = (dec.kind == K_NOP) || (dec.kind == K_ALUR) ||
                     (dec.kind == K_ALUI) || (dec.kind == K_BR);
    end else begin : g_mem_slot
      assign legal = (dec.kind == K_NOP) || (dec.kind == K_LOAD) ||
                     (dec.kind == K_STORE);
    end
  endgenerate
endmodule

// File: rtl/dis_hazard.sv
module dis_hazard
  import dis_pkg::*;
(
  input  logic             wr0_en,
  input  logic [REG_W-1:0] wr0_reg,
  input  srcs_t            src0,
  input  srcs_t            src1,
  input  logic             ld_pend,
  input  logic [REG_W-1:0] ld_reg,
  output logic             intra_hit,
  output logic             lu_hit
);
  assign intra_hit = wr0_en && uses_reg(src1, wr0_reg);
  assign lu_hit    = ld_pend && (uses_reg(src0, ld_reg) || uses_reg(src1, ld_reg));
endmodule

// File: rtl/dis_issue_ctl.sv
module dis_issue_ctl
  import dis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic             legal,
  input  logic             lu_hit,
  input  logic             intra_hit,
  input  logic             nop0,
  input  logic             nop1,
  input  logic             s1_load,
  input  logic [REG_W-1:0] s1_dst,
  output logic             issue0,
  output logic             issue1,
  output logic             hold,
  output logic             illegal,
  output logic             ld_pend,
  output logic [REG_W-1:0] ld_reg,
  output logic             lu_stall,
  output logic             split_first
);
  logic second_half;
  logic go0, go1;

  always_comb begin
    go0 = 1'b0; go1 = 1'b0; hold = 1'b0; illegal = 1'b0;
    lu_stall = 1'b0; split_first = 1'b0;
    if (pkt_valid) begin
      if (second_half) begin
        go1 = 1'b1;
      end else if (!legal) begin
        illegal = 1'b1;
      end else if (lu_hit) begin
        lu_stall = 1'b1;
        hold     = 1'b1;
      end else if (intra_hit) begin
        split_first = 1'b1;
        go0         = 1'b1;
        hold        = 1'b1;
      end else begin
        go0 = 1'b1;
        go1 = 1'b1;
      end
    end
  end

  assign issue0 = go0 && !nop0;
  assign issue1 = go1 && !nop1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_half <= 1'b0;
      ld_pend     <= 1'b0;
      ld_reg      <= '0;
    end else begin
      if (pkt_valid) second_half <= split_first;
      ld_pend <= go1 && s1_load && (s1_dst != '0);
      ld_reg  <= s1_dst;
    end
  end
endmodule

// File: rtl/dual_issue_checker.sv
module dual_issue_checker
  import dis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [PKT_W-1:0] pkt_word,
  output logic             issue0_o,
  output logic             issue1_o,
  output logic             fetch_hold_o,
  output logic             illegal_o
);
  dec_t             dec [2];
  logic [1:0]       slot_legal;
  logic             intra_hit, lu_hit, lu_stall, split_first;
  logic             ld_pend;
  logic [REG_W-1:0] ld_reg;

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_slot
      dis_slot_decode #(.SLOT(gi)) u_dec (
        .insn  (pkt_word[gi*INSN_W +: INSN_W]),
        .dec   (dec[gi]),
        .legal (slot_legal[gi])
      );
    end
  endgenerate

  dis_hazard u_haz (
    .wr0_en    (dec[0].wr_en),
    .wr0_reg   (dec[0].wr_reg),
    .src0      (dec[0].src),
    .src1      (dec[1].src),
    .ld_pend   (ld_pend),
    .ld_reg    (ld_reg),
    .intra_hit (intra_hit),
    .lu_hit    (lu_hit)
  );

  dis_issue_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_valid   (pkt_valid),
    .legal       (&slot_legal),
    .lu_hit      (lu_hit),
    .intra_hit   (intra_hit),
    .nop0        (dec[0].kind == K_NOP),
    .nop1        (dec[1].kind == K_NOP),
    .s1_load     (dec[1].wr_en && dec[1].kind == K_LOAD),
    .s1_dst      (dec[1].wr_reg),
    .issue0      (issue0_o),
    .issue1      (issue1_o),
    .hold        (fetch_hold_o),
    .illegal     (illegal_o),
    .ld_pend     (ld_pend),
    .ld_reg      (ld_reg),
    .lu_stall    (lu_stall),
    .split_first (split_first)
  );
endmodule

// File: rtl/dual_issue_checker_sva.sv
module dual_issue_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic pkt_valid,
  input logic issue0_o,
  input logic issue1_o,
  input logic fetch_hold_o,
  input logic illegal_o,
  input logic lu_stall,
  input logic split_first
);
  p_illegal_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!issue0_o && !issue1_o && !fetch_hold_o));

  p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_o, lu_stall, split_first}));

  p_stall_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lu_stall |-> (fetch_hold_o && !issue0_o && !issue1_o));

  p_stall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lu_stall |=> !lu_stall);

  p_split_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (split_first && issue0_o) |=>
      (!pkt_valid || (issue1_o && !issue0_o && !fetch_hold_o)));

  p_hold_no_slot1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hold_o |-> !issue1_o);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> (!issue0_o && !issue1_o && !fetch_hold_o && !illegal_o));
endmodule

bind dual_issue_checker dual_issue_checker_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .pkt_valid    (pkt_valid),
  .issue0_o     (issue0_o),
  .issue1_o     (issue1_o),
  .fetch_hold_o (fetch_hold_o),
  .illegal_o    (illegal_o),
  .lu_stall     (lu_stall),
  .split_first  (split_first)
);

// File: tb/dual_issue_checker_tb.sv
`timescale 1ns/1ps
module dual_issue_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [63:0] pkt_word = '0;
  logic        issue0_o, issue1_o, fetch_hold_o, illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  bit       m_half = 0;
  bit       m_ldv = 0;
  bit [4:0] m_ldr = '0;
  bit       last_hold = 0;

  always #4 clk = ~clk;

  dual_issue_checker u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_word(pkt_word),
    .issue0_o(issue0_o), .issue1_o(issue1_o),
    .fetch_hold_o(fetch_hold_o), .illegal_o(illegal_o)
  );

  function automatic [31:0] i_alur(input [4:0] rd, input [4:0] rs, input [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, 6'h20};
  endfunction
  function automatic [31:0] i_alui(input [4:0] rt, input [4:0] rs);
    return {6'h08, rs, rt, 16'h0011};
  endfunction
  function automatic [31:0] i_br(input [4:0] rs, input [4:0] rt);
    return {6'h04, rs, rt, 16'h0003};
  endfunction
  function automatic [31:0] i_ld(input [4:0] rt, input [4:0] rs);
    return {6'h23, rs, rt, 16'h0004};
  endfunction
  function automatic [31:0] i_st(input [4:0] rt, input [4:0] rs);
    return {6'h2B, rs, rt, 16'h0008};
  endfunction
  localparam [31:0] I_BAD = {6'h3F, 26'h0000abc};

  // 0 nop, 1 alu-reg, 2 alu-imm, 3 branch, 4 load, 5 store, 6 illegal
  function automatic int kind_of(input [31:0] w);
    if (w == 32'd0) return 0;
    case (w[31:26])
      6'h00: return 1;
      6'h08: return 2;
      6'h04: return 3;
      6'h23: return 4;
      6'h2B: return 5;
      default: return 6;
    endcase
  endfunction
  function automatic [4:0] dst_of(input [31:0] w);
    int k = kind_of(w);
    if (k == 1) return w[15:11];
    if (k == 2 || k == 4) return w[20:16];
    return 5'd0;
  endfunction
  function automatic bit reads(input [31:0] w, input [4:0] r);
    int k = kind_of(w);
    if (r == 5'd0) return 0;
    if (k == 1 || k == 3 || k == 5) return (w[25:21] == r) || (w[20:16] == r);
    if (k == 2 || k == 4) return w[25:21] == r;
    return 0;
  endfunction

  task automatic check(input string tag, input [3:0] act, input [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {issue0,issue1,hold,illegal} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One cycle: drive, evaluate at the falling edge, advance model at the rising edge.
  task automatic step(input bit v, input [63:0] p, input string force_tag);
    bit g0 = 0, g1 = 0, h = 0, il = 0, sp = 0;
    string tag = "R4";
    int c0, c1;
    bit [31:0] s0, s1;
    pkt_valid = v; pkt_word = p;
    s0 = p[31:0]; s1 = p[63:32];
    c0 = kind_of(s0); c1 = kind_of(s1);
    if (!v) tag = "R9";
    else if (m_half) begin g1 = 1; tag = "R6"; end
    else if (c0 > 3 || !(c1 == 0 || c1 == 4 || c1 == 5)) begin il = 1; tag = "R3"; end
    else if (m_ldv && (reads(s0, m_ldr) || reads(s1, m_ldr))) begin h = 1; tag = "R5"; end
    else if (dst_of(s0) != 0 && reads(s1, dst_of(s0))) begin g0 = 1; h = 1; sp = 1; tag = "R6"; end
    else begin g0 = 1; g1 = 1; end
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    check(tag, {issue0_o, issue1_o, fetch_hold_o, illegal_o},
          {g0 && c0 != 0, g1 && c1 != 0, h, il});
    @(posedge clk);
    if (v) m_half = sp;
    m_ldv = g1 && c1 == 4 && dst_of(s1) != 0;
    m_ldr = dst_of(s1);
    last_hold = h;
    #1;
  endtask

  task automatic send(input [63:0] p, input string tag);
    step(1, p, tag);
    while (last_hold) step(1, p, tag);
  endtask

  function automatic [4:0] rr();
    return 5'($urandom_range(0, 3));
  endfunction
  function automatic [31:0] rnd0();
    case ($urandom_range(0, 9))
      0: return 32'd0;
      1, 2: return i_alur(rr(), rr(), rr());
      3, 4: return i_alui(rr(), rr());
      5: return i_br(rr(), rr());
      6: return I_BAD;
      default: return i_alui(rr(), rr());
    endcase
  endfunction
  function automatic [31:0] rnd1();
    case ($urandom_range(0, 9))
      0: return 32'd0;
      1, 2, 3: return i_ld(rr(), rr());
      4, 5, 6: return i_st(rr(), rr());
      7: return i_alur(rr(), rr(), rr());
      default: return i_ld(rr(), rr());
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet while reset is applied and straight after it
    @(negedge clk);
    check("R1", {issue0_o, issue1_o, fetch_hold_o, illegal_o}, 4'b0000);
    @(posedge clk); rst_n = 1'b1; #1;
    step(0, 64'd0, "R1");
    // R1: a reader of any register issues whole as the first packet
    step(1, {i_st(5'd2, 5'd3), i_alur(5'd4, 5'd2, 5'd3)}, "R1");

    // R2/R4: load plus arithmetic, whole issue
    send({i_ld(5'd2, 5'd1), i_alur(5'd3, 5'd4, 5'd5)}, "R2");
    // R5: slot 0 reads the loaded register -> stall then issue
    send({32'd0, i_alui(5'd6, 5'd2)}, "R5");
    // R5: slot 1 store data reads the loaded register
    send({i_ld(5'd7, 5'd1), i_br(5'd1, 5'd1)}, "R4");
    send({i_st(5'd7, 5'd1), 32'd0}, "R5");
    // R7: load into r0 creates no pending load
    send({i_ld(5'd0, 5'd1), 32'd0}, "R7");
    send({32'd0, i_alur(5'd5, 5'd0, 5'd0)}, "R7");
    // R6: slot 1 base written by slot 0 -> split
    send({i_st(5'd1, 5'd6), i_alui(5'd6, 5'd1)}, "R6");
    // R7: same-packet write of r0 does not split
    send({i_ld(5'd3, 5'd0), i_alur(5'd0, 5'd1, 5'd2)}, "R7");
    // R6 priority: load-use stall before split
    send({i_ld(5'd9, 5'd1), 32'd0}, "R4");
    send({i_st(5'd8, 5'd8), i_alui(5'd8, 5'd9)}, "R6");
    // R3: wrong kinds in either slot, priority over load-use
    send({i_ld(5'd10, 5'd1), 32'd0}, "R4");
    send({32'd0, i_ld(5'd11, 5'd10)}, "R3");
    send({i_alur(5'd1, 5'd2, 5'd3), 32'd0}, "R3");
    send({32'd0, I_BAD}, "R2");
    // R8: no-op packets
    send(64'd0, "R8");
    send({i_ld(5'd12, 5'd1), 32'd0}, "R8");
    // R9: an empty cycle covers the load latency
    step(0, 64'd0, "R9");
    send({32'd0, i_alui(5'd1, 5'd12)}, "R9");

    // random stream
    for (int n = 0; n < 2500; n++) begin
      if ($urandom_range(0, 9) == 0) step(0, {rnd1(), rnd0()}, "");
      send({rnd1(), rnd0()}, "");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule